// File: doc/BRIEF.md
# PWM Phase Multiplier with Tri-State Recovery

This block takes one pulse-width-modulated control stream and fans its pulses out over several output channels in turn, so that a controller with few phase outputs can steer a larger number of power stages. Each output channel is a pair of bits: a data bit and a drive enable. A channel can therefore be driven high, driven low or left at high impedance. The input arrives already classified into a logic level and a tri-state flag. Both are brought into the sampling clock domain through a synchronizer and then cleaned by a minimum pulse width filter.

A mode input picks one of two layouts. In pair mode, input pulses alternate between channels 0 and 1, which gives two phases 180 degrees apart, each at half the input rate. In full mode, input pulses rotate through channels 0 to 3, which gives phases 0, 90, 180 and 270 degrees, each at a quarter of the input rate. The mode is captured once, when power-good rises.

When the input tri-state flag is set, every channel is released at once. After a tri-state period, the first pulse goes to channel 0 alone. Rotation then resumes at channel 1 on the next rising edge. Channels that have not been reached again stay at high impedance until their first pulse.

Top module: `pwm_phase_split`

## Requirements
- R1: `mode_sel` is sampled on the first clock edge at which `pwr_ok` is seen high after being low, or after reset. Value 1 selects pair mode and value 0 selects full mode. Later changes of `mode_sel` have no effect until `pwr_ok` has gone low and risen again.
- R2: One clock edge after `pwr_ok` is low, every bit of `ch_oe` and `ch_data` is 0.
- R3: In pair mode, successive accepted rising edges of the input go alternately to bit 0 and bit 1 of the channel buses. Bits 2 and 3 of `ch_oe` stay 0.
- R4: In full mode, successive accepted rising edges go to bits 0, 1, 2, 3, then wrap to 0. At most one bit of `ch_data` is 1 at any time.
- R5: The selected channel drives `ch_data` high while the filtered input is high. When the input falls, the channel drives low (`ch_oe`=1, `ch_data`=0) and keeps driving low until its next turn.
- R6: SYNC_STAGES clock edges after `pwm_tri` rises, every bit of `ch_oe` and `ch_data` is 0. This holds for as long as the synchronized flag stays set.
- R7: After a tri-state period, all channels start at high impedance. The first accepted pulse drives only bit 0. The following rising edge goes to bit 1, and only channels that have had a pulse since the tri-state exit have `ch_oe` set.
- R8: A level on `pwm_lvl`, high or low, that lasts fewer than MIN_WIDTH clock cycles is ignored: the outputs and the rotation order are unchanged. A level that lasts exactly MIN_WIDTH cycles is accepted.
- R9: An accepted level change on `pwm_lvl` reaches `ch_data` SYNC_STAGES + MIN_WIDTH + 1 clock edges after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Power-good; outputs are released while low |
| mode_sel | input | 1 | Layout select, captured when power-good rises (1 pair, 0 full) |
| pwm_lvl | input | 1 | Classified input logic level |
| pwm_tri | input | 1 | Classified input tri-state flag |
| ch_data | output | NUM_CH | Per-channel drive level |
| ch_oe | output | NUM_CH | Per-channel drive enable (0 = high impedance) |

## Verification
The bench builds the block with NUM_CH=4, SYNC_STAGES=2 and MIN_WIDTH=3. With these values a two-cycle glitch and a three-cycle pulse sit on either side of the filter threshold, so both the rejected and the accepted case can be driven. The output latency is six edges, short enough to count exactly: the bench checks the output one edge before and at the edge where the change must appear. Four channels make both the two-step and the four-step rotation, and the wrap of each, visible within a few dozen pulses.

// File: rtl/psm_pkg.sv
// Package: shared types for the PWM phase multiplier.
// Assumes nothing beyond SystemVerilog 2017 packages.
package psm_pkg;

    // Layout chosen at power-up; encoding matches the mode pin level.
    typedef enum logic {
        LAYOUT_FULL = 1'b0,
        LAYOUT_PAIR = 1'b1
    } split_layout_e;

endpackage

// File: rtl/psm_sync.sv
// Module: psm_sync
// Multi-flop synchronizer for a bus of independent single-bit signals.
// Assumes each bit may be sampled separately (no bus coherency needed).
module psm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the raw inputs through STAGES flops; reset clears all stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign d_out = pipe[STAGES-1];

endmodule

// File: rtl/psm_width_filter.sv
// Module: psm_width_filter
// Accepts a new input level only after it has been seen for MIN_WIDTH
// consecutive cycles; shorter pulses of either polarity are dropped.
// Assumes the input is already synchronous. A clear forces the output low.
module psm_width_filter #(
    parameter int MIN_WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lvl_in,
    output logic lvl_out
);

    localparam int CNT_W = (MIN_WIDTH > 1) ? $clog2(MIN_WIDTH) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_WIDTH - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             held;

    // Count cycles of disagreement; commit the new level at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            held    <= 1'b0;
            run_cnt <= '0;
        end else if (lvl_in != held) begin
            if (run_cnt == CNT_LAST) begin
                held    <= lvl_in;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign lvl_out = held;

endmodule

// File: rtl/psm_rotator.sv
// Module: psm_rotator
// Routes each rising edge of the filtered level to the next channel in
// rotation, tracks which channels have been enabled since the last
// tri-state or power event, and forms the channel data/enable buses.
// Assumes lvl_in is filtered and tri_in is synchronous.
module psm_rotator
    import psm_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              mode_sel,
    input  logic              lvl_in,
    input  logic              tri_in,
    output logic [NUM_CH-1:0] ch_data,
    output logic [NUM_CH-1:0] ch_oe,
    output logic              active,
    output logic              mode_pair
);

    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [PTR_W-1:0] LAST_FULL = PTR_W'(NUM_CH - 1);
    localparam logic [PTR_W-1:0] LAST_PAIR = PTR_W'(NUM_CH / 2 - 1);

    split_layout_e     layout_q;
    logic              pwr_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  last_idx;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] sel_q;
    logic              lvl_q;
    logic              rise;
    logic              hold_off;

    assign last_idx = (layout_q == LAYOUT_PAIR) ? LAST_PAIR : LAST_FULL;
    assign rise     = lvl_in && !lvl_q;
    assign hold_off = !pwr_ok || !pwr_q || tri_in;

    // Track power-good and latch the layout on its rising edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q    <= 1'b0;
            layout_q <= LAYOUT_FULL;
        end else begin
            pwr_q <= pwr_ok;
            if (pwr_ok && !pwr_q) layout_q <= split_layout_e'(mode_sel);
        end
    end

    // Advance the rotation on each rising edge; clear it on tri-state or power loss.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_off) begin
            ptr_q <= '0;
            en_q  <= '0;
            sel_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_in;
            if (rise) begin
                sel_q        <= '0;
                sel_q[ptr_q] <= 1'b1;
                en_q[ptr_q]  <= 1'b1;
                ptr_q        <= (ptr_q == last_idx) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // Drive only enabled channels, and only while powered and not tri-stated.
    always_comb begin
        ch_oe   = en_q & {NUM_CH{pwr_q && !tri_in}};
        ch_data = ch_oe & sel_q & {NUM_CH{lvl_q}};
    end

    assign active    = pwr_q;
    assign mode_pair = (layout_q == LAYOUT_PAIR);

endmodule

// File: rtl/pwm_phase_split.sv
// Module: pwm_phase_split (top)
// Synchronizes the classified PWM input, filters short pulses and spreads
// the pulses over NUM_CH channels in pair or full layout.
// Assumes pwr_ok is synchronous to clk; tri flag bypasses the width filter.
module pwm_phase_split #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_WIDTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              mode_sel,
    input  logic              pwm_lvl,
    input  logic              pwm_tri,
    output logic [NUM_CH-1:0] ch_data,
    output logic [NUM_CH-1:0] ch_oe
);

    logic [1:0] raw_bus;
    logic [1:0] sync_bus;
    logic       lvl_sync;
    logic       tri_sync;
    logic       lvl_filt;
    logic       rot_active;
    logic       rot_mode_pair;

    assign raw_bus  = {pwm_tri, pwm_lvl};
    assign lvl_sync = sync_bus[0];
    assign tri_sync = sync_bus[1];

    psm_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_bus),
        .d_out (sync_bus)
    );

    psm_width_filter #(
        .MIN_WIDTH (MIN_WIDTH)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tri_sync),
        .lvl_in  (lvl_sync),
        .lvl_out (lvl_filt)
    );

    psm_rotator #(
        .NUM_CH (NUM_CH)
    ) u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .mode_sel  (mode_sel),
        .lvl_in    (lvl_filt),
        .tri_in    (tri_sync),
        .ch_data   (ch_data),
        .ch_oe     (ch_oe),
        .active    (rot_active),
        .mode_pair (rot_mode_pair)
    );

endmodule

// File: rtl/psm_checker.sv
// Module: psm_checker
// Temporal properties of the phase multiplier, bound into the top.
// Assumes NUM_CH is even and at least 2.
module psm_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic              tri_sync,
    input logic              active,
    input logic              mode_pair,
    input logic [NUM_CH-1:0] ch_data,
    input logic [NUM_CH-1:0] ch_oe
);

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(mode_pair)); // R1

    AST_OFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (ch_oe == '0 && ch_data == '0)); // R2

    AST_PAIR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_pair) |-> (ch_oe[NUM_CH-1:NUM_CH/2] == '0)); // R3

    AST_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_data)); // R4

    AST_TRI_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        tri_sync |-> (ch_oe == '0)); // R6

    AST_RECOVER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tri_sync) && !tri_sync) |-> (ch_oe == '0)); // R7

endmodule

bind pwm_phase_split psm_checker #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .tri_sync  (tri_sync),
    .active    (rot_active),
    .mode_pair (rot_mode_pair),
    .ch_data   (ch_data),
    .ch_oe     (ch_oe)
);

// File: tb/pwm_phase_split_tb.sv
module pwm_phase_split_tb;

    localparam int NCH = 4;
    localparam int SYN = 2;
    localparam int MW  = 3;
    localparam int LAT = SYN + MW + 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           pwr_ok;
    logic           mode_sel;
    logic           pwm_lvl;
    logic           pwm_tri;
    logic [NCH-1:0] ch_data;
    logic [NCH-1:0] ch_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_phase_split #(
        .NUM_CH      (NCH),
        .SYNC_STAGES (SYN),
        .MIN_WIDTH   (MW)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .mode_sel (mode_sel),
        .pwm_lvl  (pwm_lvl),
        .pwm_tri  (pwm_tri),
        .ch_data  (ch_data),
        .ch_oe    (ch_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive a full-width high pulse and its low gap, checking both halves.
    task automatic pulse_chk(input string req, input logic [NCH-1:0] exp_data, input logic [NCH-1:0] exp_oe);
        pwm_lvl = 1'b1;
        step(LAT);
        chk({req, " data high"}, ch_data, exp_data);
        chk({req, " enable high"}, ch_oe, exp_oe);
        pwm_lvl = 1'b0;
        step(LAT);
        chk({req, " data low"}, ch_data, '0);
        chk({req, " enable low"}, ch_oe, exp_oe);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pwr_ok = 1'b0; mode_sel = 1'b0; pwm_lvl = 1'b0; pwm_tri = 1'b0;
        step(3);
        chk("R2 reset enable", ch_oe, '0);
        chk("R2 reset data", ch_data, '0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_full_rotation;
        mode_sel = 1'b0; pwr_ok = 1'b1;
        step(1);
        mode_sel = 1'b1;   // R1: must be ignored after capture
        step(2);
        for (int k = 0; k < 8; k++) begin
            logic [NCH-1:0] oe_exp;
            oe_exp = (k < NCH) ? NCH'((1 << (k + 1)) - 1) : '1;
            pulse_chk($sformatf("R4 R5 full rotation pulse %0d", k), NCH'(1 << (k % NCH)), oe_exp);
        end
    endtask

    task automatic t_latency;
        pwm_lvl = 1'b1;
        step(LAT - 1);
        chk("R9 rise not early", ch_data, '0);
        step(1);
        chk("R9 rise on time", ch_data, 4'b0001);
        pwm_lvl = 1'b0;
        step(LAT - 1);
        chk("R9 fall not early", ch_data, 4'b0001);
        step(1);
        chk("R9 fall on time", ch_data, '0);
    endtask

    task automatic t_glitch;
        pwm_lvl = 1'b1; step(MW - 1); pwm_lvl = 1'b0;
        step(LAT + 2);
        chk("R8 short high ignored data", ch_data, '0);
        chk("R8 short high ignored enable", ch_oe, '1);
        pwm_lvl = 1'b1; step(MW); pwm_lvl = 1'b0;
        step(LAT);
        pwm_lvl = 1'b1;
        step(LAT);
        chk("R8 width-MIN pulse accepted, next goes to ch2", ch_data, 4'b0100);
        pwm_lvl = 1'b0; step(MW - 1); pwm_lvl = 1'b1;
        step(LAT + 2);
        chk("R8 short low ignored", ch_data, 4'b0100);
        pwm_lvl = 1'b0;
        step(LAT);
        chk("R5 low after pulse", ch_data, '0);
        pwm_lvl = 1'b1;
        step(LAT);
        chk("R8 rotation not advanced by glitch", ch_data, 4'b1000);
    endtask

    task automatic t_tristate;
        pwm_tri = 1'b1;
        step(SYN);
        chk("R6 tri release enable", ch_oe, '0);
        chk("R6 tri release data", ch_data, '0);
        step(4);
        chk("R6 tri held", ch_oe, '0);
        pwm_tri = 1'b0;          // exit with level still high
        step(2);
        chk("R7 no drive before recovery pulse", ch_oe, '0);
        step(LAT + 2);
        chk("R7 recovery pulse on ch0 data", ch_data, 4'b0001);
        chk("R7 recovery pulse on ch0 enable", ch_oe, 4'b0001);
        pwm_lvl = 1'b0;
        step(LAT);
        chk("R7 recovery fall drives low", ch_oe, 4'b0001);
        chk("R7 recovery fall data", ch_data, '0);
        pulse_chk("R7 rotation resumes on ch1", 4'b0010, 4'b0011);
    endtask

    task automatic t_pair_mode;
        pwr_ok = 1'b0;
        step(2);
        chk("R2 power loss enable", ch_oe, '0);
        chk("R2 power loss data", ch_data, '0);
        mode_sel = 1'b1; pwr_ok = 1'b1;
        step(1);
        mode_sel = 1'b0;         // R1: ignored after capture
        step(2);
        for (int k = 0; k < 4; k++) begin
            logic [NCH-1:0] oe_exp;
            oe_exp = (k == 0) ? 4'b0001 : 4'b0011;
            pulse_chk($sformatf("R1 R3 pair pulse %0d", k), NCH'(1 << (k % 2)), oe_exp);
        end
    endtask

    initial begin
        t_reset;
        t_full_rotation;
        t_latency;
        t_glitch;
        t_tristate;
        t_pair_mode;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule